// File: doc/BRIEF.md
# Bus Idle Cycle Inserter

This block sits in an external bus controller, in front of the state machine that runs bus cycles. When the controller has a cycle ready, it raises a request carrying the target chip-select area and the direction. The block remembers the area and direction of the last cycle it released. It decides whether idle bus states must come before the new cycle starts. Idle states are needed when a read follows a read in a different area. A slow device from the earlier read may still be driving the data bus, and the idle states give it time to let go.

Each of the eight areas has one select bit. The bit picks one of two global 2-bit length fields. A field value of k gives k+1 idle states. While idle states run, the block asserts `busHold` and the requester keeps its request steady. No chip select or read strobe is driven during that time. The cycle is released through `cycleGo`. Address, strobe and wait-state generation are handled elsewhere.

Top module: `bus_idle_inserter`

## Requirements
- R1: When a request is present (`reqValid`=1) and no idle state is required or pending, `cycleGo` is 1 in that same cycle and `busHold` is 0.
- R2: With `cfgEnable`=0, no request ever causes `busHold`.
- R3: With `cfgEnable`=1, a read (`reqRead`=1) whose previous released cycle was a read to a different area asserts `busHold` from the request's first cycle and withholds `cycleGo` until the idle states are done.
- R4: The number of idle states is the chosen 2-bit field plus one: 00 gives 1, 01 gives 2, 10 gives 3, 11 gives 4. `cycleGo` rises in the cycle right after the last idle state.
- R5: The length field is chosen by bit `cfgSelect[reqArea]` of the new cycle's area: 0 picks `cfgLenA`, 1 picks `cfgLenB`.
- R6: A read to the same area as the previous released read inserts no idle state.
- R7: No idle state is inserted when the new cycle is a write (`reqRead`=0) or when the previous released cycle was a write.
- R8: After reset no previous cycle is recorded, so the first request after reset inserts no idle state.
- R9: The previous-cycle record is kept however many clocks pass between requests, so neither the earlier cycle's length nor a gap changes the decision.
- R10: `busHold` and `cycleGo` are never 1 in the same cycle, and a hold run never lasts more than 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A bus cycle is waiting to start |
| reqArea | input | 3 | Chip-select area of the waiting cycle |
| reqRead | input | 1 | 1 = read cycle, 0 = write cycle |
| cfgEnable | input | 1 | Enables idle insertion between reads to different areas |
| cfgSelect | input | 8 | Per-area choice of idle length field (0 = A, 1 = B) |
| cfgLenA | input | 2 | Idle length field A (states minus one) |
| cfgLenB | input | 2 | Idle length field B (states minus one) |
| busHold | output | 1 | Idle state in progress; requester must wait |
| cycleGo | output | 1 | The waiting cycle starts its first bus state now |

## Verification
The checker assumes three things. A requester that sees `busHold` keeps `reqValid`, `reqArea` and `reqRead` unchanged until `cycleGo`. The configuration inputs do not change while a hold is running. The requester drops or replaces its request after `cycleGo`. Without these, the length and enable properties could see a decision made on different inputs. The bench changes configuration only between requests, while `reqValid` is low. It holds each request steady from the edge where it is presented until the cycle where `cycleGo` is seen, and it clears `reqValid` right after.

// File: rtl/idle_ins_pkg.sv
package idle_ins_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;  // start an idle run with the selected length
    logic decCnt;   // one idle state consumed
    logic record;   // remember the cycle being released
  } idleStrobes_t;
endpackage

// File: rtl/idle_ins_dp.sv
module idle_ins_dp
  import idle_ins_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int LEN_W     = 2,
  localparam int AREA_W   = $clog2(NUM_AREAS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  idleStrobes_t         strobes,
  input  logic [AREA_W-1:0]    reqArea,
  input  logic                 reqRead,
  input  logic                 cfgEnable,
  input  logic [NUM_AREAS-1:0] cfgSelect,
  input  logic [LEN_W-1:0]     cfgLenA,
  input  logic [LEN_W-1:0]     cfgLenB,
  output logic                 needIdle,
  output logic                 cntZero
);
  logic              prevValid;
  logic              prevRead;
  logic [AREA_W-1:0] prevArea;
  logic [LEN_W-1:0]  idleCnt;
  logic [LEN_W-1:0]  selLen;

  // length field chosen by the new cycle's area
  assign selLen = cfgSelect[reqArea] ? cfgLenB : cfgLenA;

  assign needIdle = cfgEnable && prevValid && prevRead && reqRead &&
                    (reqArea != prevArea);
  assign cntZero  = (idleCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevRead  <= 1'b0;
      prevArea  <= '0;
    end else if (strobes.record) begin
      prevValid <= 1'b1;
      prevRead  <= reqRead;
      prevArea  <= reqArea;
    end
  end

  // counter holds idle states still to run after the current one
  always_ff @(posedge clk) begin
    if (!rstN)                idleCnt <= '0;
    else if (strobes.loadCnt) idleCnt <= selLen;
    else if (strobes.decCnt)  idleCnt <= idleCnt - 1'b1;
  end
endmodule

// File: rtl/idle_ins_ctrl.sv
module idle_ins_ctrl
  import idle_ins_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         needIdle,
  input  logic         cntZero,
  output idleStrobes_t strobes,
  output logic         busHold,
  output logic         cycleGo
);
  logic waiting;
  logic waitingNext;

  always_comb begin
    strobes     = '0;
    busHold     = 1'b0;
    cycleGo     = 1'b0;
    waitingNext = waiting;
    if (waiting) begin
      if (cntZero) begin
        cycleGo        = 1'b1;
        strobes.record = 1'b1;
        waitingNext    = 1'b0;
      end else begin
        busHold        = 1'b1;
        strobes.decCnt = 1'b1;
      end
    end else if (reqValid) begin
      if (needIdle) begin
        busHold         = 1'b1;
        strobes.loadCnt = 1'b1;
        waitingNext     = 1'b1;
      end else begin
        cycleGo        = 1'b1;
        strobes.record = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) waiting <= 1'b0;
    else       waiting <= waitingNext;
  end
endmodule

// File: rtl/bus_idle_inserter.sv
module bus_idle_inserter
  import idle_ins_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int LEN_W     = 2,
  localparam int AREA_W   = $clog2(NUM_AREAS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [AREA_W-1:0]    reqArea,
  input  logic                 reqRead,
  input  logic                 cfgEnable,
  input  logic [NUM_AREAS-1:0] cfgSelect,
  input  logic [LEN_W-1:0]     cfgLenA,
  input  logic [LEN_W-1:0]     cfgLenB,
  output logic                 busHold,
  output logic                 cycleGo
);
  idleStrobes_t strobes;
  logic needIdle;
  logic cntZero;

  idle_ins_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .needIdle(needIdle),
    .cntZero(cntZero), .strobes(strobes), .busHold(busHold), .cycleGo(cycleGo)
  );

  idle_ins_dp #(.NUM_AREAS(NUM_AREAS), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqArea(reqArea),
    .reqRead(reqRead), .cfgEnable(cfgEnable), .cfgSelect(cfgSelect),
    .cfgLenA(cfgLenA), .cfgLenB(cfgLenB), .needIdle(needIdle), .cntZero(cntZero)
  );
endmodule

// File: rtl/bus_idle_inserter_chk.sv
module bus_idle_inserter_chk #(
  parameter int NUM_AREAS = 8,
  parameter int LEN_W     = 2,
  localparam int AREA_W   = $clog2(NUM_AREAS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic [AREA_W-1:0]    reqArea,
  input logic                 reqRead,
  input logic                 cfgEnable,
  input logic [NUM_AREAS-1:0] cfgSelect,
  input logic [LEN_W-1:0]     cfgLenA,
  input logic [LEN_W-1:0]     cfgLenB,
  input logic                 busHold,
  input logic                 cycleGo
);
  localparam int MAX_IDLE = 1 << LEN_W;

  logic              lastValid;
  logic              lastRead;
  logic [AREA_W-1:0] lastArea;
  logic [LEN_W+1:0]  holdRun;
  logic [LEN_W:0]    expRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastValid <= 1'b0;
      lastRead  <= 1'b0;
      lastArea  <= '0;
      holdRun   <= '0;
    end else begin
      if (cycleGo) begin
        lastValid <= 1'b1;
        lastRead  <= reqRead;
        lastArea  <= reqArea;
      end
      if (busHold) holdRun <= holdRun + 1'b1;
      else         holdRun <= '0;
    end
  end

  assign expRun = (cfgSelect[reqArea] ? {1'b0, cfgLenB} : {1'b0, cfgLenA}) + 1'b1;

  a_r10_go_hold_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busHold && cycleGo));
  a_r10_hold_bounded: assert property (@(posedge clk) disable iff (!rstN)
    holdRun <= (LEN_W+2)'(MAX_IDLE));
  a_r1_go_when_free: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busHold) |-> cycleGo);
  a_r2_disabled_no_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |-> !busHold);
  a_r7_reads_only: assert property (@(posedge clk) disable iff (!rstN)
    busHold |-> (reqRead && lastRead));
  a_r6_same_area: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && lastValid && reqArea == lastArea) |-> !busHold);
  a_r8_first_free: assert property (@(posedge clk) disable iff (!rstN)
    !lastValid |-> !busHold);
  a_r4_idle_len: assert property (@(posedge clk) disable iff (!rstN)
    (cycleGo && holdRun != '0) |-> (holdRun == (LEN_W+2)'(expRun)));
endmodule

bind bus_idle_inserter bus_idle_inserter_chk #(.NUM_AREAS(NUM_AREAS), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqArea(reqArea), .reqRead(reqRead),
  .cfgEnable(cfgEnable), .cfgSelect(cfgSelect), .cfgLenA(cfgLenA), .cfgLenB(cfgLenB),
  .busHold(busHold), .cycleGo(cycleGo)
);

// File: tb/bus_idle_inserter_bench.sv
module bus_idle_inserter_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqArea = '0;
  logic       reqRead = 1'b0;
  logic       cfgEnable = 1'b0;
  logic [7:0] cfgSelect = 8'b1010_0101;
  logic [1:0] cfgLenA = '0;
  logic [1:0] cfgLenB = '0;
  logic       busHold;
  logic       cycleGo;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_idle_inserter u_bus_idle_inserter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqArea(reqArea), .reqRead(reqRead),
    .cfgEnable(cfgEnable), .cfgSelect(cfgSelect), .cfgLenA(cfgLenA), .cfgLenB(cfgLenB),
    .busHold(busHold), .cycleGo(cycleGo)
  );

  // {enable, lenA, lenB, area, read, expected idle states}
  // cfgSelect = 1010_0101: areas 0,2,5,7 use B, others use A
  localparam logic [11:0] VEC [15] = '{
    {1'b1, 2'd0, 2'd3, 3'd0, 1'b1, 3'd0},  // R8 first read after reset
    {1'b1, 2'd0, 2'd3, 3'd0, 1'b1, 3'd0},  // R6 same area
    {1'b1, 2'd0, 2'd3, 3'd1, 1'b1, 3'd1},  // R3 R4 R5 area1 -> A=00
    {1'b1, 2'd0, 2'd3, 3'd2, 1'b1, 3'd4},  // R4 R5 area2 -> B=11
    {1'b1, 2'd1, 2'd2, 3'd3, 1'b0, 3'd0},  // R7 new cycle is a write
    {1'b1, 2'd1, 2'd2, 3'd4, 1'b1, 3'd0},  // R7 previous was a write
    {1'b1, 2'd1, 2'd2, 3'd5, 1'b1, 3'd3},  // R4 R5 area5 -> B=10
    {1'b0, 2'd1, 2'd2, 3'd6, 1'b1, 3'd0},  // R2 disabled
    {1'b1, 2'd2, 2'd1, 3'd7, 1'b1, 3'd2},  // R4 area7 -> B=01
    {1'b1, 2'd2, 2'd1, 3'd6, 1'b1, 3'd3},  // R5 new area6 bit 0 -> A=10
    {1'b1, 2'd2, 2'd1, 3'd6, 1'b0, 3'd0},  // R7 write
    {1'b1, 2'd3, 2'd0, 3'd1, 1'b0, 3'd0},  // R7 write after write
    {1'b1, 2'd3, 2'd0, 3'd3, 1'b1, 3'd0},  // R7 read after write
    {1'b1, 2'd3, 2'd0, 3'd4, 1'b1, 3'd4},  // R4 area4 -> A=11
    {1'b1, 2'd3, 2'd0, 3'd0, 1'b1, 3'd1}   // R5 area0 -> B=00
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // present one request, count hold cycles until go, compare
  task automatic runReq(input logic [2:0] area, input logic rd, input int exp, input string req);
    int n = 0;
    bit holdOk = 1;
    @(negedge clk);
    reqArea = area; reqRead = rd; reqValid = 1'b1;
    #1;
    while (!cycleGo && n < 10) begin
      if (!busHold) holdOk = 0;
      n++;
      @(negedge clk);
      #1;
    end
    check(n == exp, req, n, exp);
    check(holdOk && !busHold, "R10 hold until go", int'(busHold), 0);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!busHold && !cycleGo, "R1 reset idle outputs", int'({busHold, cycleGo}), 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(!busHold && !cycleGo, "R1 no request", int'({busHold, cycleGo}), 0);

    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      {cfgEnable, cfgLenA, cfgLenB} = VEC[i][11:7];
      runReq(VEC[i][6:4], VEC[i][3], int'(VEC[i][2:0]), $sformatf("table %0d", i));
    end

    // R9: long gap after a read still inserts idle on an area change
    cfgEnable = 1'b1; cfgLenA = 2'd1; cfgLenB = 2'd0;
    runReq(3'd2, 1'b1, 1, "R5 setup area2 B");
    repeat (5) @(negedge clk);
    runReq(3'd1, 1'b1, 2, "R9 gap keeps record");

    // R8: reset clears the record
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    runReq(3'd6, 1'b1, 0, "R8 first read after reset");
    runReq(3'd7, 1'b1, 1, "R3 after reset recorded");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule